// File: doc/BRIEF.md
# Program Counter and Branch-Select Unit

This block keeps the program counter of a single-cycle processor and decides, every clock, where the next instruction comes from. It takes decoded control-flow flags from the decoder, both register operands and the target address computed by the ALU. Three shared comparators test the operands for equality, for signed order and for unsigned order. An AND-OR tree combines those results with the flags into one redirect decision. On the next edge the program counter loads either the ALU target or its own value plus four.

The unit drives four results. The current program counter goes to the ALU. The incremented value goes to the register file as the link value for jumps. The redirect decision is available for observation. The word index goes to an instruction memory that holds one instruction per address. That index is the byte-style program counter shifted right by two.

Top module: `pc_steer_unit`

## Requirements
- R1: A synchronous active-high `rst` sampled at a rising edge loads the program counter with 0, so `pc_now` and `fetch_word` read 0 after that edge. Reset takes priority over any flag.
- R2: When `take_redirect` is 0, each rising edge loads the program counter with its current value plus 4, wrapping modulo 2^32 (0xFFFFFFFC is followed by 0x00000000). With `flow_kind` all zero, `take_redirect` is 0.
- R3: When `take_redirect` is 1, the next rising edge loads the program counter with `alu_target`.
- R4: `flow_kind` bit 6 (direct jump) and bit 7 (register-indirect jump) set `take_redirect` to 1 whatever the operand values.
- R5: `flow_kind` bit 0 redirects only when `opnd_a == opnd_b`. Bit 1 redirects only when they differ.
- R6: `flow_kind` bit 2 redirects only when `opnd_a < opnd_b` as two's-complement numbers. Bit 3 redirects only when that test is false.
- R7: `flow_kind` bit 4 redirects only when `opnd_a < opnd_b` as unsigned numbers. Bit 5 redirects only when that test is false.
- R8: `pc_link` always equals `pc_now + 4` modulo 2^32, combinationally.
- R9: `fetch_word` always equals `pc_now` shifted right by 2. It depends only on the program counter register, so input changes between edges leave it unchanged.
- R10: `take_redirect` is the combinational redirect decision for the flags and operands present in the current cycle. At most one bit of `flow_kind` is set at a time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| flow_kind | input | 8 | One-hot control-flow flags: bits 0-5 are the conditional branches, bit 6 is the direct jump, bit 7 is the indirect jump |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| alu_target | input | 32 | Redirect target computed by the ALU |
| pc_now | output | 32 | Current program counter |
| pc_link | output | 32 | Program counter plus 4, the link value |
| fetch_word | output | 30 | Instruction memory word index |
| take_redirect | output | 1 | Redirect decision for this cycle |

## Verification
`take_redirect` and `pc_link` are combinational, so the bench checks them in the same cycle the inputs are driven, one time step after the falling edge. `pc_now` and `fetch_word` change exactly one rising edge after the decision or reset that causes them. The reference model updates its program counter only at that edge. Its expected values are then compared at the following falling edge, after the next inputs have already changed, which shows that the fetch index ignores mid-cycle input changes.

// File: rtl/pcu_pkg.sv
package pcu_pkg;

    // Bit positions of the one-hot control-flow flag vector
    typedef enum int {
        FK_EQ_BR   = 0,
        FK_NE_BR   = 1,
        FK_LT_BR   = 2,
        FK_GE_BR   = 3,
        FK_LTU_BR  = 4,
        FK_GEU_BR  = 5,
        FK_JUMP    = 6,
        FK_JUMP_R  = 7
    } flow_bit_e;

    localparam int NUM_FLOW = 8;

    // Shared comparator results
    typedef struct packed {
        logic eq;
        logic lt_s;
        logic lt_u;
    } cmp_res_t;

endpackage

// File: rtl/pcu_compare.sv
module pcu_compare #(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]  a_i,
    input  logic [XLEN-1:0]  b_i,
    output pcu_pkg::cmp_res_t res_o
);
    always_comb begin
        res_o.eq   = (a_i == b_i);
        res_o.lt_s = ($signed(a_i) < $signed(b_i));
        res_o.lt_u = (a_i < b_i);
    end
endmodule

// File: rtl/pcu_redirect.sv
module pcu_redirect
    import pcu_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_FLOW-1:0] flow_i,
    input  cmp_res_t            cmp_i,
    output logic                redirect_o
);
    logic [NUM_FLOW-1:0] cond;
    logic [NUM_FLOW-1:0] term;

    // Condition per flag kind, chosen at elaboration
    for (genvar k = 0; k < NUM_FLOW; k++) begin : g_kind
        if (k == int'(FK_EQ_BR)) begin : g_eq
            assign cond[k] = cmp_i.eq;
        end else if (k == int'(FK_NE_BR)) begin : g_ne
            assign cond[k] = ~cmp_i.eq;
        end else if (k == int'(FK_LT_BR)) begin : g_lt
            assign cond[k] = cmp_i.lt_s;
        end else if (k == int'(FK_GE_BR)) begin : g_ge
            assign cond[k] = ~cmp_i.lt_s;
        end else if (k == int'(FK_LTU_BR)) begin : g_ltu
            assign cond[k] = cmp_i.lt_u;
        end else if (k == int'(FK_GEU_BR)) begin : g_geu
            assign cond[k] = ~cmp_i.lt_u;
        end else begin : g_uncond
            assign cond[k] = 1'b1;
        end
        assign term[k] = flow_i[k] & cond[k];
    end

    assign redirect_o = |term;

    AST_JUMP_ALWAYS: assert property (@(posedge clk) disable iff (rst)
        (flow_i[FK_JUMP] || flow_i[FK_JUMP_R]) |-> redirect_o) else $error("jump did not redirect"); // R4
    AST_IDLE_NO_REDIRECT: assert property (@(posedge clk) disable iff (rst)
        (flow_i == '0) |-> !redirect_o) else $error("redirect without flag"); // R2
    AST_EQ_NE_EXCL: assert property (@(posedge clk) disable iff (rst)
        (flow_i[FK_EQ_BR] && cmp_i.eq) |-> redirect_o) else $error("equal branch not taken"); // R5
endmodule

// File: rtl/pcu_next.sv
module pcu_next #(
    parameter int XLEN       = 32,
    parameter int STEP_BYTES = 4
) (
    input  logic [XLEN-1:0] pc_i,
    input  logic [XLEN-1:0] target_i,
    input  logic            redirect_i,
    output logic [XLEN-1:0] pc_plus_o,
    output logic [XLEN-1:0] pc_next_o
);
    localparam logic [XLEN-1:0] STEP = XLEN'(STEP_BYTES);

    always_comb begin
        pc_plus_o = pc_i + STEP;
        pc_next_o = redirect_i ? target_i : pc_plus_o;
    end
endmodule

// File: rtl/pc_steer_unit.sv
module pc_steer_unit
    import pcu_pkg::*;
#(
    parameter int XLEN        = 32,
    parameter int INSTR_BYTES = 4
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic [NUM_FLOW-1:0]             flow_kind,
    input  logic [XLEN-1:0]                 opnd_a,
    input  logic [XLEN-1:0]                 opnd_b,
    input  logic [XLEN-1:0]                 alu_target,
    output logic [XLEN-1:0]                 pc_now,
    output logic [XLEN-1:0]                 pc_link,
    output logic [XLEN-$clog2(INSTR_BYTES)-1:0] fetch_word,
    output logic                            take_redirect
);
    localparam int IDX_SHIFT = $clog2(INSTR_BYTES);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } pc_state_t;

    pc_state_t st_d, st_q;
    cmp_res_t  cmp_w;
    logic      redirect_w;
    logic [XLEN-1:0] pc_plus_w, pc_next_w;

    pcu_compare #(.XLEN(XLEN)) u_cmp (
        .a_i   (opnd_a),
        .b_i   (opnd_b),
        .res_o (cmp_w)
    );

    pcu_redirect u_sel (
        .clk        (clk),
        .rst        (rst),
        .flow_i     (flow_kind),
        .cmp_i      (cmp_w),
        .redirect_o (redirect_w)
    );

    pcu_next #(.XLEN(XLEN), .STEP_BYTES(INSTR_BYTES)) u_nxt (
        .pc_i       (st_q.pc),
        .target_i   (alu_target),
        .redirect_i (redirect_w),
        .pc_plus_o  (pc_plus_w),
        .pc_next_o  (pc_next_w)
    );

    always_comb begin
        st_d = st_q;
        if (rst) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = pc_next_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_now        = st_q.pc;
    assign pc_link       = pc_plus_w;
    assign fetch_word    = st_q.pc[XLEN-1:IDX_SHIFT];
    assign take_redirect = redirect_w;

    AST_RESET_ZERO: assert property (@(posedge clk)
        rst |=> (pc_now == '0)) else $error("reset value wrong"); // R1
    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (rst)
        !take_redirect |=> (pc_now == $past(pc_now) + XLEN'(INSTR_BYTES))) else $error("sequential step wrong"); // R2
    AST_TARGET_LOAD: assert property (@(posedge clk) disable iff (rst)
        take_redirect |=> (pc_now == $past(alu_target))) else $error("target not loaded"); // R3
endmodule

// File: tb/sim_pc_steer_unit.sv
module sim_pc_steer_unit;
    logic        clk = 1'b0;
    logic        rst;
    logic [7:0]  flow_kind;
    logic [31:0] opnd_a, opnd_b, alu_target;
    logic [31:0] pc_now, pc_link;
    logic [29:0] fetch_word;
    logic        take_redirect;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_pc;
    logic [31:0] lf = 32'h1234_5678;
    bit done = 0;

    always #5 clk = ~clk;

    pc_steer_unit u0 (
        .clk(clk), .rst(rst), .flow_kind(flow_kind), .opnd_a(opnd_a),
        .opnd_b(opnd_b), .alu_target(alu_target), .pc_now(pc_now),
        .pc_link(pc_link), .fetch_word(fetch_word), .take_redirect(take_redirect)
    );

    function automatic logic ref_taken(logic [7:0] f, logic [31:0] a, logic [31:0] b);
        case (f)
            8'h01: return a == b;
            8'h02: return a != b;
            8'h04: return $signed(a) <  $signed(b);
            8'h08: return $signed(a) >= $signed(b);
            8'h10: return a <  b;
            8'h20: return a >= b;
            8'h40, 8'h80: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(logic [7:0] f);
        case (f)
            8'h01, 8'h02: return "R5";
            8'h04, 8'h08: return "R6";
            8'h10, 8'h20: return "R7";
            8'h40, 8'h80: return "R4";
            default: return "R2";
        endcase
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive one cycle, check comb results, advance the model at the edge
    task automatic step(logic r, logic [7:0] f, logic [31:0] a, logic [31:0] b, logic [31:0] t);
        logic exp_take;
        rst = r; flow_kind = f; opnd_a = a; opnd_b = b; alu_target = t;
        #1;
        exp_take = ref_taken(f, a, b);
        check("R9 fetch_word", {2'b00, fetch_word}, m_pc >> 2);
        check("R2/R3 pc_now", pc_now, m_pc);
        check("R8 pc_link", pc_link, m_pc + 32'd4);
        check({"R10 take_redirect ", tag_of(f)}, {31'd0, take_redirect}, {31'd0, exp_take});
        @(posedge clk);
        if (r) m_pc = 32'd0;
        else if (exp_take) m_pc = t;
        else m_pc = m_pc + 32'd4;
        @(negedge clk);
    endtask

    function automatic logic [31:0] pick(logic [2:0] s);
        case (s)
            3'd0: return 32'h0000_0000;
            3'd1: return 32'h0000_0001;
            3'd2: return 32'h8000_0000;
            3'd3: return 32'hFFFF_FFFF;
            3'd4: return 32'h7FFF_FFFF;
            default: return 32'h0000_0005;
        endcase
    endfunction

    initial begin
        rst = 1'b1; flow_kind = 8'h40; opnd_a = 0; opnd_b = 0; alu_target = 32'h0000_0100;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_pc = 32'd0;
        check("R1 reset pc", pc_now, 32'd0);
        check("R1 reset fetch", {2'b00, fetch_word}, 32'd0);
        // idle stepping
        step(0, 8'h00, 32'd3, 32'd3, 32'h0000_0400);
        step(0, 8'h00, 32'd3, 32'd4, 32'h0000_0400);
        // equality branches
        step(0, 8'h01, 32'd7, 32'd7, 32'h0000_0200);
        step(0, 8'h01, 32'd7, 32'd8, 32'h0000_0300);
        step(0, 8'h02, 32'd7, 32'd8, 32'h0000_0040);
        step(0, 8'h02, 32'd9, 32'd9, 32'h0000_0080);
        // signed vs unsigned ordering on a sign-bit operand
        step(0, 8'h04, 32'h8000_0000, 32'd1, 32'h0000_1000);
        step(0, 8'h10, 32'h8000_0000, 32'd1, 32'h0000_2000);
        step(0, 8'h08, 32'h8000_0000, 32'd1, 32'h0000_3000);
        step(0, 8'h20, 32'h8000_0000, 32'd1, 32'h0000_4000);
        step(0, 8'h08, 32'd5, 32'd5, 32'h0000_5000);
        step(0, 8'h20, 32'd5, 32'd5, 32'h0000_6000);
        // jumps, then wrap of the program counter
        step(0, 8'h80, 32'd1, 32'd2, 32'h0000_0A00);
        step(0, 8'h40, 32'd1, 32'd1, 32'hFFFF_FFFC);
        step(0, 8'h00, 32'd0, 32'd0, 32'h0000_0000);
        check("R2 wrap to zero", pc_now, 32'd0);
        // reset wins over a jump flag
        step(0, 8'h40, 32'd0, 32'd0, 32'h0000_0800);
        step(1, 8'h40, 32'd0, 32'd0, 32'h0000_0900);
        check("R1 reset over jump", pc_now, 32'd0);
        // pseudo-random traffic
        for (int i = 0; i < 400; i++) begin
            logic [7:0] f;
            lf = lf ^ (lf << 13); lf = lf ^ (lf >> 17); lf = lf ^ (lf << 5);
            f = lf[6] ? (8'h01 << lf[5:3]) : 8'h00;
            step(0, f, pick(lf[9:7]), pick(lf[12:10]), {lf[31:14], 14'd0} | {18'd0, lf[13:8], 8'd0});
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule